// File: doc/BRIEF.md
# Bus Inactivity Auto Power-Down Controller

This block decides when a memory-and-logic subsystem may enter standby by watching the address-latch-enable strobe of its host bus. A host writes two 8-bit control registers through a simple write strobe and can read both back. One register arms automatic power-down, sets the strobe level that counts as idle, and drives static gating outputs: a memory current-saving enable, a logic-array turbo disable, and disconnect controls for the array clock and the macrocell clock. The other register picks the source of the power-down counter clock and drives a sleep-mode enable.

Automatic power-down counts only while it is fully armed and the strobe rests at the programmed idle level. Any strobe activity clears the count. The counter advances on rising edges of the selected source, either the main clock input pin or an alternate port input. The strobe and both clock pins pass through two-flop synchronizers, so all logic runs on the single system clock. After fifteen counted rising edges the standby output goes high. It stays high until the bus shows activity again or the host disarms power-down. When turbo is off and the array clock is connected, each change on the main clock input gives a one-cycle wake pulse for the logic array.

Top module: `apd_ctrl`

## Requirements
- R1: After a synchronous reset, both registers read 0, and standby, sleep_en, mem_save_en, turbo_off, array_clk_dis, mcell_clk_dis and array_wake are all 0.
- R2: Register 0 (wr_addr/rd_addr = 0) reads back all 8 written bits. Register 1 (address 1) reads back written bits 1:0, and bits 7:2 always read 0.
- R3: mem_save_en follows register 0 bit 3, turbo_off follows bit 4, array_clk_dis follows bit 5 and mcell_clk_dis follows bit 6. sleep_en follows register 1 bit 1.
- R4: Power-down is armed only when register 0 bits 0, 2 and 7 are all 1. While it is not armed, standby stays 0 whatever the strobe and clock inputs do.
- R5: Register 1 bit 0 selects the counter source: 1 selects main_clk_in and 0 selects alt_clk_in. Edges on the source that is not selected do not count.
- R6: When armed, with ale_in held at the level in register 0 bit 1, standby is 0 after 14 rising edges of the selected source and goes to 1 after the 15th.
- R7: The count saturates. Further rising edges keep standby at 1, and it does not wrap.
- R8: Any ale_in transition, or ale_in held at the level opposite to register 0 bit 1, clears the count. Standby is 0 by the third clock edge after the pin changes, and stays 0 while the strobe is at the opposite level.
- R9: A write that leaves register 0 not armed brings standby to 0 by the second clock edge after the write edge.
- R10: array_wake pulses for one cycle on each change of main_clk_in only while turbo_off is 1 and array_clk_dis is 0. Otherwise it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 = register 0, 1 = register 1 |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read select: 0 = register 0, 1 = register 1 |
| rd_data | output | 8 | Read data of the selected register |
| ale_in | input | 1 | Address-latch-enable strobe, asynchronous |
| main_clk_in | input | 1 | Main clock input pin, slow and asynchronous |
| alt_clk_in | input | 1 | Alternate port input, slow and asynchronous |
| standby | output | 1 | Standby request |
| sleep_en | output | 1 | Sleep-mode enable |
| mem_save_en | output | 1 | Memory current-saving enable |
| turbo_off | output | 1 | Logic-array turbo disable |
| array_clk_dis | output | 1 | Array clock disconnect |
| mcell_clk_dis | output | 1 | Macrocell clock disconnect |
| array_wake | output | 1 | One-cycle wake pulse for the logic array |

## Verification
The assertions assume the two clock pins toggle no faster than once every two system clocks, so that every pin edge shows up as one synchronized edge. They also assume reset is held low for at least one edge at start-up. The stimulus holds each clock-pin level for two system clocks. It changes the counter-source selection only while power-down is disarmed, so a change of selection cannot be counted as an edge. Register writes are single-cycle strobes driven between clock edges.

// File: rtl/apd_pkg.sv
// Package: shared widths and register bit positions for the auto power-down controller.
// Assumes: registers are 8 bits wide. The bit positions below are decoded by the datapath.
package apd_pkg;
    localparam int REG_W        = 8;
    // register 0 bit positions
    localparam int B0_ARM_LO    = 0;
    localparam int B0_IDLE_POL  = 1;
    localparam int B0_APD_EN    = 2;
    localparam int B0_MEM_SAVE  = 3;
    localparam int B0_TURBO_OFF = 4;
    localparam int B0_ARR_DIS   = 5;
    localparam int B0_MC_DIS    = 6;
    localparam int B0_ARM_HI    = 7;
    // register 1 bit positions
    localparam int B1_CLK_SEL   = 0;
    localparam int B1_SLEEP     = 1;
    localparam int B1_USED      = 2;
    // default number of counted edges before standby
    localparam int IDLE_LIMIT   = 15;
endpackage

// File: rtl/apd_sync.sv
// Module: apd_sync
// Two-flop synchronizer, one chain per bit, built with generate.
// Assumes: inputs are level signals that change more slowly than clk.
module apd_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic s1, s2;
        // double-register one asynchronous bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d_async[i];
                s2 <= s1;
            end
        end
        assign q_sync[i] = s2;
    end
endmodule

// File: rtl/apd_regs.sv
// Module: apd_regs
// Holds the two power-management control registers, their read mux and the arm decode.
// Assumes: a single-cycle write strobe. Register 1 stores only its implemented bits.
module apd_regs
    import apd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] reg0,
    output logic [REG_W-1:0] reg1,
    output logic             armed
);
    localparam int PAD_W = REG_W - B1_USED;

    logic [B1_USED-1:0] reg1_q;

    // register writes with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg0   <= '0;
            reg1_q <= '0;
        end else if (wr_en) begin
            if (!wr_addr) reg0   <= wr_data;
            else          reg1_q <= wr_data[B1_USED-1:0];
        end
    end

    assign reg1 = {{PAD_W{1'b0}}, reg1_q};

    // read mux
    always_comb begin
        rd_data = rd_addr ? reg1 : reg0;
    end

    // arm decode: both marker bits and the enable bit must be set
    always_comb begin
        armed = reg0[B0_ARM_LO] & reg0[B0_ARM_HI] & reg0[B0_APD_EN];
    end

    a_r2_reg0_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr) |=> (reg0 == $past(wr_data)));

    a_r2_reg1_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr) |=> (reg1[B1_USED-1:0] == $past(wr_data[B1_USED-1:0])));
endmodule

// File: rtl/apd_counter.sv
// Module: apd_counter
// Saturating idle counter. Standby is high when the count reaches LIMIT.
// Assumes: clr and tick are single-clock-domain qualifiers. clr wins over tick.
module apd_counter #(
    parameter int LIMIT = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic standby
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] MAXV = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // clear on activity, otherwise count ticks up to the limit
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (clr)                  cnt <= '0;
        else if (tick && cnt != MAXV)  cnt <= cnt + 1'b1;
    end

    assign standby = (cnt == MAXV);

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= MAXV);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !clr) |=> standby);

    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == '0 || cnt == CW'($past(cnt) + 1'b1)));

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !standby);
endmodule

// File: rtl/apd_ctrl.sv
// Module: apd_ctrl (top)
// Bus-inactivity power-down controller: registers, synchronizers, strobe and clock
// edge detection, counter-source selection, the idle counter and the gating outputs.
// Assumes: ale_in and both clock pins are asynchronous and slower than clk.
module apd_ctrl
    import apd_pkg::*;
#(
    parameter int LIMIT = IDLE_LIMIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             ale_in,
    input  logic             main_clk_in,
    input  logic             alt_clk_in,
    output logic             standby,
    output logic             sleep_en,
    output logic             mem_save_en,
    output logic             turbo_off,
    output logic             array_clk_dis,
    output logic             mcell_clk_dis,
    output logic             array_wake
);
    localparam int NSYNC = 3;
    localparam int S_ALE = 0;
    localparam int S_MCK = 1;
    localparam int S_ACK = 2;

    logic [REG_W-1:0] reg0, reg1;
    logic             armed;
    logic [NSYNC-1:0] pins_s;
    logic             ale_p, mck_p, src_p;
    logic             src_s, ale_act, src_rise, clr;

    apd_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .reg0    (reg0),
        .reg1    (reg1),
        .armed   (armed)
    );

    apd_sync #(.WIDTH(NSYNC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({alt_clk_in, main_clk_in, ale_in}),
        .q_sync  (pins_s)
    );

    // pick the counter source
    always_comb begin
        src_s = reg1[B1_CLK_SEL] ? pins_s[S_MCK] : pins_s[S_ACK];
    end

    // previous synchronized values for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_p <= 1'b0;
            mck_p <= 1'b0;
            src_p <= 1'b0;
        end else begin
            ale_p <= pins_s[S_ALE];
            mck_p <= pins_s[S_MCK];
            src_p <= src_s;
        end
    end

    // activity, tick and clear qualifiers
    always_comb begin
        ale_act  = (pins_s[S_ALE] != ale_p) || (pins_s[S_ALE] != reg0[B0_IDLE_POL]);
        src_rise = src_s && !src_p;
        clr      = !armed || ale_act;
    end

    apd_counter #(.LIMIT(LIMIT)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .tick    (src_rise),
        .standby (standby)
    );

    // static gating outputs
    always_comb begin
        mem_save_en   = reg0[B0_MEM_SAVE];
        turbo_off     = reg0[B0_TURBO_OFF];
        array_clk_dis = reg0[B0_ARR_DIS];
        mcell_clk_dis = reg0[B0_MC_DIS];
        sleep_en      = reg1[B1_SLEEP];
    end

    // wake pulse on any main-clock change when turbo is off and the array clock is connected
    always_comb begin
        array_wake = turbo_off && !array_clk_dis && (pins_s[S_MCK] != mck_p);
    end

    a_r4_off_no_standby: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !standby);   // also covers R9

    a_r8_ale_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_s[S_ALE] != ale_p) |=> !standby);

    a_r10_wake_gate: assert property (@(posedge clk) disable iff (!rst_n)
        array_wake |-> (turbo_off && !array_clk_dis));
endmodule

// File: tb/apd_ctrl_bench.sv
module apd_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       ale_in = 1'b0;
    logic       main_clk_in = 1'b0;
    logic       alt_clk_in = 1'b0;
    logic       standby, sleep_en, mem_save_en, turbo_off;
    logic       array_clk_dis, mcell_clk_dis, array_wake;

    int checks = 0;
    int errors = 0;
    int wake_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    apd_ctrl u_apd_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ale_in(ale_in), .main_clk_in(main_clk_in), .alt_clk_in(alt_clk_in),
        .standby(standby), .sleep_en(sleep_en), .mem_save_en(mem_save_en),
        .turbo_off(turbo_off), .array_clk_dis(array_clk_dis),
        .mcell_clk_dis(mcell_clk_dis), .array_wake(array_wake)
    );

    // count wake pulses away from the active edge
    always @(negedge clk) if (array_wake) wake_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input bit a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // n rising edges on the chosen pin (1 = main, 0 = alternate), two cycles per level
    task automatic pulses(input bit main, input int n);
        for (int i = 0; i < n; i++) begin
            if (main) main_clk_in = 1'b1; else alt_clk_in = 1'b1;
            settle(2);
            if (main) main_clk_in = 1'b0; else alt_clk_in = 1'b0;
            settle(2);
        end
        settle(4);
    endtask

    // arm with idle polarity pol and source sel; the source changes only while disarmed
    task automatic arm(input bit pol, input bit sel);
        wreg(1'b0, 8'h00);
        wreg(1'b1, {7'd0, sel});
        ale_in = pol;
        settle(5);
        wreg(1'b0, 8'h85 | {6'd0, pol, 1'b0});
        settle(2);
    endtask

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(1);
        // R1 reset state
        rd_addr = 1'b0; #1 chk("R1 reg0", rd_data, 0);
        rd_addr = 1'b1; #1 chk("R1 reg1", rd_data, 0);
        chk("R1 outputs", {standby, sleep_en, mem_save_en, turbo_off,
                           array_clk_dis, mcell_clk_dis, array_wake}, 0);

        // R2 and R3: sweep of all values for both registers
        for (int v = 0; v < 256; v++) begin
            wreg(1'b0, 8'(v));
            wreg(1'b1, 8'(v));
            rd_addr = 1'b0; #1 chk("R2 reg0 readback", rd_data, v);
            rd_addr = 1'b1; #1 chk("R2 reg1 readback", rd_data, v & 3);
            chk("R3 gating", {mem_save_en, turbo_off, array_clk_dis, mcell_clk_dis, sleep_en},
                {v[3], v[4], v[5], v[6], v[1]});
        end
        wreg(1'b0, 8'h00);
        wreg(1'b1, 8'h00);
        ale_in = 1'b0;
        settle(5);

        // R5, R6, R7, R8 for both polarities and both sources
        for (int pol = 0; pol < 2; pol++) begin
            for (int sel = 0; sel < 2; sel++) begin
                arm(pol[0], sel[0]);
                pulses(!sel[0], 20);
                chk("R5 other source ignored", standby, 0);
                pulses(sel[0], 14);
                chk("R6 not before 15", standby, 0);
                pulses(sel[0], 1);
                chk("R6 standby at 15", standby, 1);
                pulses(sel[0], 5);
                chk("R7 saturated", standby, 1);
                ale_in = !pol[0]; settle(1);
                ale_in = pol[0];
                settle(3);
                chk("R8 pulse clears", standby, 0);
                pulses(sel[0], 15);
                chk("R6 recount", standby, 1);
                ale_in = !pol[0];
                settle(3);
                chk("R8 opposite level clears", standby, 0);
                pulses(sel[0], 20);
                chk("R8 opposite level holds", standby, 0);
                ale_in = pol[0];
                settle(5);
            end
        end

        // R4 and R9: drop each arming bit in turn
        for (int k = 0; k < 3; k++) begin
            logic [7:0] bad;
            bad = (k == 0) ? 8'h84 : (k == 1) ? 8'h81 : 8'h05;
            arm(1'b0, 1'b1);
            pulses(1'b1, 15);
            chk("R6 armed before drop", standby, 1);
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 1'b0; wr_data = bad;
            @(negedge clk);
            wr_en = 1'b0;
            @(negedge clk);
            chk("R9 disarm clears", standby, 0);
            pulses(1'b1, 20);
            chk("R4 disarmed stays low", standby, 0);
        end

        // R10 wake gating
        wreg(1'b1, 8'h01);
        for (int m = 0; m < 3; m++) begin
            logic [7:0] cfg;
            int exp;
            cfg = (m == 0) ? 8'h10 : (m == 1) ? 8'h30 : 8'h00;
            exp = (m == 0) ? 4 : 0;
            wreg(1'b0, cfg);
            settle(2);
            wake_cnt = 0;
            pulses(1'b1, 2);
            chk("R10 wake count", wake_cnt, exp);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule